// File: doc/BRIEF.md
# ECC Error Event Capture Unit

This block sits next to an on-chip RAM controller and keeps a record of ECC error events. Each cycle the controller can report two kinds of error. One is a single-bit error that was corrected. The other is a multi-bit error that could not be corrected. With either report it supplies the access address, a size code, a four-bit attribute code, the requesting master's identifier and the 64-bit data word. If reporting is switched on for that class of error, the block takes a snapshot of all these fields. It also raises a sticky flag for that class.

Software reaches the block through a simple word-addressed register bus. Through it, software turns reporting on or off for each class, reads and clears the flags, and reads the snapshot. Only the most recent enabled event is kept: a later enabled event overwrites the snapshot. The snapshot registers have no reset value.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset the enable register (offset 0) and the flag register (offset 1) read as zero, and `reg_rdata` is zero.
- R2: A corrected event (`ev_single`) while enable bit 0 is set does two things. It loads the address, size, attribute, master and data into the snapshot. It sets flag bit 0.
- R3: An uncorrectable event (`ev_multi`) while enable bit 1 is set does two things. It loads the address, size, attribute and master into the snapshot and sets flag bit 1. The captured data is undefined in this case.
- R4: An event whose class enable bit is clear leaves the snapshot and both flags unchanged.
- R5: Each enabled event replaces the whole snapshot left by the previous one.
- R6: A write to offset 1 clears every flag whose `reg_wdata` bit is 1 and leaves the rest alone. If an enabled event of the same class arrives in the clearing cycle, the flag stays set.
- R7: If both indications arrive in one cycle and both classes are enabled, both flags are set. The snapshot then records the uncorrectable class, shown by attribute bit 3 = 1. Attribute bit 3 = 0 marks a corrected capture.
- R8: Offsets 2 to 5 (address, attribute, data high, data low) are read-only, and bus writes to them change nothing.
- R9: `reg_rdata` shows the addressed register in the cycle after `reg_rd` is asserted. Offset 4 returns data bits 63:32 and offset 5 returns bits 31:0. Offsets 6 and 7 read as zero.
- R10: The attribute word holds the captured fields at fixed positions:
  - Bits 2:0 hold the size code: 000 for 8-bit, 001 for 16-bit, 010 for 32-bit and 011 for 64-bit. Codes 1xx are reserved and are stored as they arrive.
  - Bits 7:4 hold the attribute code. From bit 7 down to bit 4 these are: cacheable, bufferable, supervisor (1) or user (0), and data (1) or instruction fetch (0).
  - Bits 15:8 hold the master identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_single | input | 1 | Corrected single-bit error this cycle |
| ev_multi | input | 1 | Uncorrectable multi-bit error this cycle |
| ev_addr | input | AW | Address of the failing access |
| ev_size | input | 3 | Access size code |
| ev_prot | input | 4 | Access attribute code |
| ev_master | input | MW | Requesting master identifier |
| ev_data | input | 64 | Data of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |

## Verification
The hardest case to reach from the ports is a flag-clearing write and a new enabled event of the same class in the same clock cycle. The bench drives the bus write strobe and the error indication on the same falling edge, so both land on the same rising edge, and then reads the flag register back. A sweep over every enable setting and every pairing of the two indications covers the remaining corners. These include the priority case and the disabled-class case. A separate sweep walks all 128 size and attribute codes through the attribute word.

// File: rtl/ecc_event_capture.sv
module ecc_event_capture #(
  parameter int AW = 32,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_single,
  input  logic          ev_multi,
  input  logic [AW-1:0] ev_addr,
  input  logic [2:0]    ev_size,
  input  logic [3:0]    ev_prot,
  input  logic [MW-1:0] ev_master,
  input  logic [63:0]   ev_data,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata
);
  localparam logic [2:0] OFS_CFG  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_ADDR = 3'd2;
  localparam logic [2:0] OFS_ATTR = 3'd3;
  localparam logic [2:0] OFS_DHI  = 3'd4;
  localparam logic [2:0] OFS_DLO  = 3'd5;

  logic          en_cor, en_unc, fl_cor, fl_unc;
  logic [AW-1:0] cap_addr;
  logic [2:0]    cap_size;
  logic [3:0]    cap_prot;
  logic [MW-1:0] cap_mst;
  logic          cap_cls;
  logic [63:0]   cap_data;
  logic [31:0]   rd_mux;
  logic          unused_wdata;

  wire wr_cfg   = reg_wr && (reg_addr == OFS_CFG);
  wire wr_stat  = reg_wr && (reg_addr == OFS_STAT);
  wire take_cor = ev_single && en_cor;
  wire take_unc = ev_multi && en_unc;
  wire clr_cor  = wr_stat && reg_wdata[0];
  wire clr_unc  = wr_stat && reg_wdata[1];

  assign unused_wdata = ^reg_wdata[31:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_cor <= 1'b0;
      en_unc <= 1'b0;
      fl_cor <= 1'b0;
      fl_unc <= 1'b0;
    end else begin
      if (wr_cfg) begin
        en_cor <= reg_wdata[0];
        en_unc <= reg_wdata[1];
      end
      fl_cor <= (fl_cor && !clr_cor) || take_cor;
      fl_unc <= (fl_unc && !clr_unc) || take_unc;
    end
  end

  always_ff @(posedge clk) begin
    if (take_cor || take_unc) begin
      cap_addr <= ev_addr;
      cap_size <= ev_size;
      cap_prot <= ev_prot;
      cap_mst  <= ev_master;
      cap_cls  <= take_unc;
      cap_data <= ev_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CFG:  rd_mux[1:0] = {en_unc, en_cor};
      OFS_STAT: rd_mux[1:0] = {fl_unc, fl_cor};
      OFS_ADDR: rd_mux[AW-1:0] = cap_addr;
      OFS_ATTR: begin
        rd_mux[2:0]     = cap_size;
        rd_mux[3]       = cap_cls;
        rd_mux[7:4]     = cap_prot;
        rd_mux[8 +: MW] = cap_mst;
      end
      OFS_DHI:  rd_mux = cap_data[63:32];
      OFS_DLO:  rd_mux = cap_data[31:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_cor_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_single && en_cor) |=> fl_cor);
  assert_unc_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_multi && en_unc) |=> fl_unc);
  assert_no_rise_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_cor && !(ev_single && en_cor)) |=> !fl_cor);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_unc && !(reg_wr && reg_addr == OFS_STAT && reg_wdata[1])) |=> fl_unc);
  assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_single && ev_multi && en_unc) |=> cap_cls);
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr[2:1] == 2'b11) |=> (reg_rdata == 32'd0));
endmodule

// File: tb/ecc_event_capture_tb.sv
module ecc_event_capture_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_single = 0, ev_multi = 0;
  logic [31:0] ev_addr = '0;
  logic [2:0] ev_size = '0;
  logic [3:0] ev_prot = '0;
  logic [7:0] ev_master = '0;
  logic [63:0] ev_data = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int vectors = 0, miscompares = 0;
  logic m_ec, m_eu, m_fc, m_fu, m_cls, m_have;
  logic [31:0] m_addr;
  logic [2:0] m_size;
  logic [3:0] m_prot;
  logic [7:0] m_mst;
  logic [63:0] m_data;

  always #10 clk = ~clk;

  ecc_event_capture u_dut (.clk(clk), .rst_n(rst_n), .ev_single(ev_single), .ev_multi(ev_multi),
    .ev_addr(ev_addr), .ev_size(ev_size), .ev_prot(ev_prot), .ev_master(ev_master),
    .ev_data(ev_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a == 3'd0) begin m_ec = d[0]; m_eu = d[1]; end
    if (a == 3'd1) begin if (d[0]) m_fc = 0; if (d[1]) m_fu = 0; end
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic model_event(input logic s, input logic m);
    logic tc, tu;
    tc = s && m_ec; tu = m && m_eu;
    if (tc) m_fc = 1;
    if (tu) m_fu = 1;
    if (tc || tu) begin
      m_have = 1; m_cls = tu; m_addr = ev_addr; m_size = ev_size;
      m_prot = ev_prot; m_mst = ev_master; m_data = ev_data;
    end
  endtask

  task automatic fire(input logic s, input logic m, input int seed);
    @(negedge clk);
    ev_single = s; ev_multi = m;
    ev_addr = 32'h1000_0000 + seed * 8; ev_size = seed[2:0]; ev_prot = seed[6:3];
    ev_master = 8'h40 + seed[7:0]; ev_data = {32'hC0DE_0000 ^ seed, 32'h0BAD_F00D + seed};
    model_event(s, m);
    @(negedge clk); ev_single = 0; ev_multi = 0;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    bus_rd(3'd0, d); check(req, d, {30'd0, m_eu, m_ec});
    bus_rd(3'd1, d); check(req, d, {30'd0, m_fu, m_fc});
    if (m_have) begin
      bus_rd(3'd2, d); check(req, d, m_addr);
      bus_rd(3'd3, d); check(req, d, {16'd0, m_mst, m_prot, m_cls, m_size});
      if (!m_cls) begin
        bus_rd(3'd4, d); check(req, d, m_data[63:32]);
        bus_rd(3'd5, d); check(req, d, m_data[31:0]);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_ec = 0; m_eu = 0; m_fc = 0; m_fu = 0; m_cls = 0; m_have = 0;
    m_addr = '0; m_size = '0; m_prot = '0; m_mst = '0; m_data = '0;
    repeat (3) @(negedge clk);
    check("R1 rdata", reg_rdata, 32'd0);
    rst_n = 1;
    check_all("R1 reset");

    // R2 R3 R4 R5 R7: every enable setting against every indication pairing
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 4; p++) begin
        bus_wr(3'd0, c);
        fire(p[0], p[1], c * 4 + p + 1);
        check_all("R2/R3/R4/R5/R7 sweep");
        bus_wr(3'd1, 32'd3);
      end

    // R10: all size and attribute codes
    bus_wr(3'd0, 32'd1);
    for (int sz = 0; sz < 8; sz++)
      for (int pr = 0; pr < 16; pr++) begin
        fire(1, 0, pr * 8 + sz);
        bus_rd(3'd3, d); check("R10 attr", d, {16'd0, m_mst, m_prot, 1'b0, m_size});
      end

    // R6: selective clear, zero write, same-cycle clear and event
    bus_wr(3'd0, 32'd3);
    fire(1, 1, 77);
    bus_wr(3'd1, 32'd0); check_all("R6 zero write");
    bus_wr(3'd1, 32'd1); check_all("R6 clear bit0 only");
    fire(1, 0, 78);
    @(negedge clk); reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'd1; ev_single = 1;
    ev_addr = 32'h2222_0000; ev_size = 3'd3; ev_prot = 4'hA; ev_master = 8'h11;
    ev_data = 64'hFEED_FACE_0123_4567;
    m_cls = 0; m_addr = ev_addr; m_size = ev_size; m_prot = ev_prot; m_mst = ev_master;
    m_data = ev_data; m_fc = 1;
    @(negedge clk); reg_wr = 0; ev_single = 0;
    check_all("R6 clear with event");

    // R8: writes to captured registers ignored
    for (int a = 2; a < 6; a++) bus_wr(a[2:0], 32'hDEAD_BEEF);
    check_all("R8 read-only");

    // R9: unmapped offsets and latency
    bus_rd(3'd6, d); check("R9 off6", d, 32'd0);
    bus_rd(3'd7, d); check("R9 off7", d, 32'd0);
    @(negedge clk); reg_rd = 1; reg_addr = 3'd4;
    @(negedge clk); reg_rd = 0; reg_addr = 3'd0;
    check("R9 latency", reg_rdata, m_data[63:32]);
    @(negedge clk); check("R9 hold", reg_rdata, m_data[63:32]);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule